// File: doc/BRIEF.md
# Two-Wire Register Access Target

This block is the target side of a two-wire serial link (I2C/SMBus style) that opens a window onto a bank of eight 16-bit registers. A host selects the target with a 7-bit address. The upper four bits of that address are a fixed preamble, 0011. The lower three bits come from strap inputs. After that the host either writes a register or reads one back. A register pointer keeps the last selected register. A read that sends no pointer byte therefore returns the register the pointer selects now. A write that carries only a pointer byte, followed by a repeated START, gives a read from any chosen register.

The raw SCL and SDA levels are synchronised and filtered in the system clock domain. START, STOP and repeated START are recognised from the filtered levels. SDA is returned as an open-drain enable. The register bank sits outside the block and is reached through a simple port: a pointer output, a 16-bit write word with a one-cycle strobe that fires at STOP, and a combinational read word. If SCL is held low for longer than a set number of cycles during a transaction, the interface is forced back to idle and SDA is released.

The controller walks through seven states:
- `ST_IDLE`: the bus is idle.
- `ST_ADDR`: the target is shifting in the address byte.
- `ST_ACK`: the target drives an acknowledge.
- `ST_RX`: the target is receiving a pointer or data byte.
- `ST_TX`: the target is sending a data byte.
- `ST_TXACK`: the target samples the host's acknowledge.
- `ST_WAITSTOP`: the target has stepped back until the next START or STOP.

The transitions are:
- A START, whether a first or a repeated one, leads from any state to `ST_ADDR`.
- A STOP or a timeout leads from any state to `ST_IDLE`.
- At the falling edge that closes the eighth address bit, `ST_ADDR` goes to `ST_ACK` when the address matches and to `ST_WAITSTOP` when it does not.
- At the end of the ninth clock, `ST_ACK` goes to `ST_TX` after a read address and to `ST_RX` after any other acknowledged byte.
- After a byte, `ST_RX` goes to `ST_ACK` while the byte is one of the first three. It goes to `ST_WAITSTOP` for any byte after those.
- After eight bits, `ST_TX` goes to `ST_TXACK`.
- `ST_TXACK` goes back to `ST_TX` when the host acknowledges and to `ST_WAITSTOP` when the host does not.

Top module: `regbus_serial_target`

## Requirements
- R1: An address byte equal to {0011, strap_i[2:0], rw} is acknowledged by driving SDA low during the ninth clock, with rw=1 meaning read and rw=0 meaning write. Any other address byte gets no acknowledge, and SDA stays released until the next START or STOP.
- R2: A write is the address, then a pointer byte, then the data MSB byte, then the data LSB byte, and each byte is acknowledged. The following STOP raises reg_we_o for exactly one clock cycle, with reg_addr_o equal to the low three bits of the pointer byte and reg_wdata_o equal to {MSB, LSB}.
- R3: A write that reaches STOP without both data bytes causes no write strobe. A write cut short by a repeated START also causes no write strobe.
- R4: The low three bits of a received pointer byte set the pointer as soon as that byte completes. A pointer-only write followed by a repeated START and a read address returns the newly selected register.
- R5: A read address returns the register at the current pointer, MSB byte first and each byte MSB bit first. A host acknowledge after the MSB byte leads to the LSB byte. A host non-acknowledge ends the transfer with SDA released.
- R6: After reset, sda_oe_o is 0, reg_we_o is 0 and the pointer (reg_addr_o) is 0.
- R7: After a complete write, further bytes before STOP are not acknowledged, and the STOP still commits the two data bytes already received.
- R8: Incoming bits are sampled on the filtered SCL rising edge. sda_oe_o and the pointer change only while the filtered SCL is low.
- R9: If the filtered SCL stays low for TOUT_CYC consecutive cycles while a transaction is open, the interface returns to idle and releases SDA. A later transaction then works normally.
- R10: A pulse on SCL or SDA lasting fewer than FILT_CYC system clock cycles has no effect on the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw serial clock level from the pad |
| sda_i | input | 1 | Raw serial data level from the pad |
| strap_i | input | 3 | Board straps forming the low three address bits |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| reg_addr_o | output | 3 | Register pointer |
| reg_wdata_o | output | 16 | Word to write |
| reg_we_o | output | 1 | One-cycle write strobe issued at STOP |
| reg_rdata_i | input | 16 | Word read from the register at reg_addr_o |

## Verification
The cycle-level assertions watch four rules on every clock. SDA drive and the pointer move only while the filtered clock is low. The write strobe is a single cycle that falls while the filtered clock is high. A timeout releases SDA on the very next cycle. The bench scenarios are what show the transaction-level behaviour: address matching, and how the pointer byte selects what a later immediate or selective read returns. They also show that short, pointer-only and repeated-START-interrupted writes are dropped, that surplus bytes go unacknowledged, that the bus recovers after a timeout, and that short glitches on both lines leave a transfer intact.

// File: rtl/regbus_serial_target_pkg.sv
package regbus_serial_target_pkg;
    localparam int REG_AW   = 3;
    localparam int WORD_W   = 16;
    localparam int BYTE_W   = 8;
    localparam int STRAP_W  = 3;
    localparam logic [3:0] ADDR_PREAMBLE = 4'b0011;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_RX,
        ST_TX,
        ST_TXACK,
        ST_WAITSTOP
    } tgt_state_t;
endpackage

// File: rtl/line_deglitch.sv
module line_deglitch #(
    parameter int FILT_CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    localparam int CW = $clog2(FILT_CYC + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q  <= 2'b11;
            run_q   <= '0;
            clean_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], raw_i};
            if (sync_q[1] == clean_o) begin
                run_q <= '0;
            end else if (run_q == CW'(FILT_CYC - 1)) begin
                run_q   <= '0;
                clean_o <= sync_q[1];
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/bus_cond_detect.sv
module bus_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_c,
    input  logic sda_c,
    output logic scl_rise,
    output logic scl_fall,
    output logic cond_start,
    output logic cond_stop
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_c;
            sda_q <= sda_c;
        end
    end

    always_comb begin
        scl_rise   = scl_c & ~scl_q;
        scl_fall   = ~scl_c & scl_q;
        cond_start = scl_c & scl_q & sda_q & ~sda_c;
        cond_stop  = scl_c & scl_q & ~sda_q & sda_c;
    end
endmodule

// File: rtl/scl_low_watch.sv
module scl_low_watch #(
    parameter int TOUT_CYC = 2_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic scl_c,
    output logic tout_hit
);
    localparam int TW = $clog2(TOUT_CYC + 1);

    logic [TW-1:0] low_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt_q <= '0;
        end else if (!busy || scl_c || tout_hit) begin
            low_cnt_q <= '0;
        end else begin
            low_cnt_q <= low_cnt_q + 1'b1;
        end
    end

    assign tout_hit = busy && !scl_c && (low_cnt_q == TW'(TOUT_CYC - 1));
endmodule

// File: rtl/tgt_xfer_fsm.sv
module tgt_xfer_fsm
    import regbus_serial_target_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_rise,
    input  logic                scl_fall,
    input  logic                sda_bit,
    input  logic                cond_start,
    input  logic                cond_stop,
    input  logic                tout,
    input  logic [STRAP_W-1:0]  strap,
    input  logic [WORD_W-1:0]   rdata,
    output logic                sda_oe,
    output logic [REG_AW-1:0]   ptr,
    output logic [WORD_W-1:0]   wdata,
    output logic                we,
    output logic                busy
);
    localparam int BC_W = $clog2(BYTE_W);

    tgt_state_t        state_q, state_d;
    logic [BC_W-1:0]   bitcnt_q;
    logic              got_byte_q;
    logic [BYTE_W-1:0] rx_sh_q;
    logic [BYTE_W-1:0] tx_sh_q;
    logic [WORD_W-1:0] tx_word_q;
    logic              tx_lsb_q;
    logic              host_ack_q;
    logic              ack_tx_q;
    logic [1:0]        wr_idx_q;
    logic              wr_full_q;
    logic              addr_hit;

    assign addr_hit = (rx_sh_q[BYTE_W-1:1] == {ADDR_PREAMBLE, strap});

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (tout || cond_stop) begin
            state_d = ST_IDLE;
        end else if (cond_start) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_ADDR:     if (scl_fall && got_byte_q)
                                 state_d = addr_hit ? ST_ACK : ST_WAITSTOP;
                ST_ACK:      if (scl_fall)
                                 state_d = ack_tx_q ? ST_TX : ST_RX;
                ST_RX:       if (scl_fall && got_byte_q)
                                 state_d = (wr_idx_q == 2'd3) ? ST_WAITSTOP : ST_ACK;
                ST_TX:       if (scl_fall && got_byte_q)
                                 state_d = ST_TXACK;
                ST_TXACK:    if (scl_fall)
                                 state_d = host_ack_q ? ST_TX : ST_WAITSTOP;
                ST_WAITSTOP: state_d = ST_WAITSTOP;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt_q   <= '0;
            got_byte_q <= 1'b0;
            rx_sh_q    <= '0;
            tx_sh_q    <= '0;
            tx_word_q  <= '0;
            tx_lsb_q   <= 1'b0;
            host_ack_q <= 1'b0;
            ack_tx_q   <= 1'b0;
            wr_idx_q   <= '0;
            wr_full_q  <= 1'b0;
            wdata      <= '0;
            ptr        <= '0;
            we         <= 1'b0;
        end else begin
            we <= 1'b0;
            if (tout) begin
                bitcnt_q   <= '0;
                got_byte_q <= 1'b0;
                wr_idx_q   <= '0;
                wr_full_q  <= 1'b0;
            end else if (cond_stop) begin
                we         <= wr_full_q;
                got_byte_q <= 1'b0;
                wr_idx_q   <= '0;
                wr_full_q  <= 1'b0;
            end else if (cond_start) begin
                bitcnt_q   <= '0;
                got_byte_q <= 1'b0;
                wr_idx_q   <= '0;
                wr_full_q  <= 1'b0;
            end else begin
                if (scl_rise && (state_q == ST_ADDR || state_q == ST_RX || state_q == ST_TX)) begin
                    rx_sh_q  <= {rx_sh_q[BYTE_W-2:0], sda_bit};
                    bitcnt_q <= bitcnt_q + 1'b1;
                    if (bitcnt_q == BC_W'(BYTE_W - 1)) got_byte_q <= 1'b1;
                end
                if (scl_rise && state_q == ST_TXACK) host_ack_q <= ~sda_bit;
                if (scl_fall) begin
                    got_byte_q <= 1'b0;
                    unique case (state_q)
                        ST_ADDR: if (got_byte_q && addr_hit) begin
                            ack_tx_q  <= rx_sh_q[0];
                            tx_word_q <= rdata;
                            tx_sh_q   <= rdata[WORD_W-1:BYTE_W];
                            tx_lsb_q  <= 1'b0;
                        end
                        ST_RX: if (got_byte_q) begin
                            unique case (wr_idx_q)
                                2'd0: ptr <= rx_sh_q[REG_AW-1:0];
                                2'd1: wdata[WORD_W-1:BYTE_W] <= rx_sh_q;
                                2'd2: begin
                                    wdata[BYTE_W-1:0] <= rx_sh_q;
                                    wr_full_q         <= 1'b1;
                                end
                                default: ;
                            endcase
                            if (wr_idx_q != 2'd3) wr_idx_q <= wr_idx_q + 1'b1;
                        end
                        ST_TX: if (!got_byte_q) tx_sh_q <= {tx_sh_q[BYTE_W-2:0], 1'b0};
                        ST_TXACK: if (host_ack_q) begin
                            tx_lsb_q <= ~tx_lsb_q;
                            tx_sh_q  <= tx_lsb_q ? tx_word_q[WORD_W-1:BYTE_W]
                                                 : tx_word_q[BYTE_W-1:0];
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe = (state_q == ST_ACK) || (state_q == ST_TX && !tx_sh_q[BYTE_W-1]);
        busy   = (state_q != ST_IDLE);
    end
endmodule

// File: rtl/regbus_serial_target.sv
module regbus_serial_target
    import regbus_serial_target_pkg::*;
#(
    parameter int FILT_CYC = 6,
    parameter int TOUT_CYC = 2_500_000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    input  logic [STRAP_W-1:0]  strap_i,
    output logic                sda_oe_o,
    output logic [REG_AW-1:0]   reg_addr_o,
    output logic [WORD_W-1:0]   reg_wdata_o,
    output logic                reg_we_o,
    input  logic [WORD_W-1:0]   reg_rdata_i
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_lines;
    logic [NLINES-1:0] clean_lines;
    logic scl_clean, sda_clean;
    logic scl_rise, scl_fall, cond_start, cond_stop;
    logic tout_hit, busy;

    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_filt
        line_deglitch #(.FILT_CYC(FILT_CYC)) u_flt (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_i   (raw_lines[g]),
            .clean_o (clean_lines[g])
        );
    end

    assign scl_clean = clean_lines[1];
    assign sda_clean = clean_lines[0];

    bus_cond_detect u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_c      (scl_clean),
        .sda_c      (sda_clean),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .cond_start (cond_start),
        .cond_stop  (cond_stop)
    );

    scl_low_watch #(.TOUT_CYC(TOUT_CYC)) u_watch (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (busy),
        .scl_c    (scl_clean),
        .tout_hit (tout_hit)
    );

    tgt_xfer_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .sda_bit    (sda_clean),
        .cond_start (cond_start),
        .cond_stop  (cond_stop),
        .tout       (tout_hit),
        .strap      (strap_i),
        .rdata      (reg_rdata_i),
        .sda_oe     (sda_oe_o),
        .ptr        (reg_addr_o),
        .wdata      (reg_wdata_o),
        .we         (reg_we_o),
        .busy       (busy)
    );
endmodule

// File: rtl/regbus_serial_target_chk.sv
module regbus_serial_target_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_clean,
    input logic       sda_oe,
    input logic       reg_we,
    input logic [2:0] reg_addr,
    input logic       tout_hit
);
    a_r8_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_clean);

    a_r4_ptr_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(reg_addr) |-> !scl_clean);

    a_r2_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    a_r2_we_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> scl_clean);

    a_r9_timeout_release: assert property (@(posedge clk) disable iff (!rst_n)
        tout_hit |=> !sda_oe);
endmodule

bind regbus_serial_target regbus_serial_target_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_clean (scl_clean),
    .sda_oe    (sda_oe_o),
    .reg_we    (reg_we_o),
    .reg_addr  (reg_addr_o),
    .tout_hit  (tout_hit)
);

// File: tb/regbus_serial_target_bench.sv
module regbus_serial_target_bench;
    localparam int TOUT = 2000;
    localparam int H    = 50;
    localparam int Q    = 25;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] AW_B  = {4'b0011, STRAP, 1'b0};
    localparam logic [7:0] AR_B  = {4'b0011, STRAP, 1'b1};
    localparam logic [18:0] VEC [4] = '{
        {3'd1, 16'h1234}, {3'd2, 16'h8001}, {3'd4, 16'hFFFF}, {3'd7, 16'h00A5}};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_h = 1'b1;
    logic sda_h = 1'b1;
    logic glitch = 1'b0;
    logic sda_line;
    logic sda_oe_o, reg_we_o;
    logic [2:0]  reg_addr_o;
    logic [15:0] reg_wdata_o, reg_rdata_i;
    logic [15:0] regs [8];
    int we_cnt = 0;
    int checks = 0;
    int errors = 0;
    int oe_hi_chg = 0;
    int cyc = 0;
    logic oe_prev = 1'b0;

    always #5 clk = ~clk;

    assign sda_line    = sda_h & ~sda_oe_o;
    assign reg_rdata_i = regs[reg_addr_o];

    regbus_serial_target #(.FILT_CYC(6), .TOUT_CYC(TOUT)) u_regbus_serial_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_line), .strap_i(STRAP),
        .sda_oe_o(sda_oe_o), .reg_addr_o(reg_addr_o), .reg_wdata_o(reg_wdata_o),
        .reg_we_o(reg_we_o), .reg_rdata_i(reg_rdata_i));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) regs[i] <= 16'hA000 + 16'(i) * 16'h0111;
        end else if (reg_we_o) begin
            regs[reg_addr_o] <= reg_wdata_o;
            we_cnt <= we_cnt + 1;
        end
    end

    // R8: device drive must not move while the bench holds SCL high
    always @(negedge clk) begin
        if (rst_n && scl_h && (sda_oe_o != oe_prev)) oe_hi_chg++;
        oe_prev = sda_oe_o;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_bit(input logic b);
        sda_h = b;
        if (glitch) begin
            wc(10); scl_h = 1'b1; wc(3); scl_h = 1'b0; wc(Q - 13);
        end else wc(Q);
        scl_h = 1'b1;
        wc(H / 2);
        if (glitch) begin
            sda_h = ~b; wc(3); sda_h = b; wc(H / 2 - 3);
        end else wc(H / 2);
        scl_h = 1'b0;
        wc(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_h = 1'b1;
        wc(Q);
        scl_h = 1'b1;
        wc(H / 2);
        b = sda_line;
        wc(H / 2);
        scl_h = 1'b0;
        wc(Q);
    endtask

    task automatic bus_start();
        sda_h = 1'b1; scl_h = 1'b1; wc(H);
        sda_h = 1'b0; wc(H);
        scl_h = 1'b0; wc(Q);
    endtask

    task automatic bus_rstart();
        sda_h = 1'b1; wc(Q);
        scl_h = 1'b1; wc(H);
        sda_h = 1'b0; wc(H);
        scl_h = 1'b0; wc(Q);
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; wc(Q);
        scl_h = 1'b1; wc(H);
        sda_h = 1'b1; wc(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        get_bit(r);
        ack = ~r;
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic give_ack);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            get_bit(r);
            b[i] = r;
        end
        put_bit(~give_ack);
    endtask

    task automatic write_full(input logic [2:0] p, input logic [15:0] d, output logic [3:0] acks);
        bus_start();
        send_byte(AW_B, acks[3]);
        send_byte({5'b0, p}, acks[2]);
        send_byte(d[15:8], acks[1]);
        send_byte(d[7:0], acks[0]);
        bus_stop();
    endtask

    task automatic read_now(output logic [15:0] w, output logic ack);
        bus_start();
        send_byte(AR_B, ack);
        recv_byte(w[15:8], 1'b1);
        recv_byte(w[7:0], 1'b0);
        bus_stop();
    endtask

    task automatic read_sel(input logic [2:0] p, output logic [15:0] w);
        logic a;
        bus_start();
        send_byte(AW_B, a);
        send_byte({5'b0, p}, a);
        bus_rstart();
        send_byte(AR_B, a);
        recv_byte(w[15:8], 1'b1);
        recv_byte(w[7:0], 1'b0);
        bus_stop();
    endtask

    initial begin
        logic [3:0]  acks;
        logic [15:0] w;
        logic        a;
        int          n0;

        wc(5);
        rst_n = 1'b1;
        wc(5);
        // R6: reset state
        chk("R6 oe", 32'(sda_oe_o), 32'd0);
        chk("R6 we", 32'(reg_we_o), 32'd0);
        chk("R6 ptr", 32'(reg_addr_o), 32'd0);

        // R5/R6: immediate read after reset returns register 0
        read_now(w, a);
        chk("R1 read addr ack", 32'(a), 32'd1);
        chk("R5 immediate read reg0", 32'(w), 32'hA000);
        chk("R5 released after nack", 32'(sda_oe_o), 32'd0);

        // R2/R4: table of writes, each verified by a selective read
        for (int i = 0; i < 4; i++) begin
            n0 = we_cnt;
            write_full(VEC[i][18:16], VEC[i][15:0], acks);
            chk("R2 acks", 32'(acks), 32'hF);
            chk("R2 one strobe", 32'(we_cnt - n0), 32'd1);
            chk("R2 reg value", 32'(regs[VEC[i][18:16]]), 32'(VEC[i][15:0]));
            read_sel(VEC[i][18:16], w);
            chk("R4 selective read", 32'(w), 32'(VEC[i][15:0]));
        end

        // R1: wrong address gets no acknowledge and no drive
        bus_start();
        send_byte(8'h38, a);
        chk("R1 mismatch nack", 32'(a), 32'd0);
        send_byte(8'h00, a);
        chk("R1 mismatch silent", 32'(a), 32'd0);
        bus_stop();

        // R3/R4: partial write (pointer + MSB) discarded, pointer moved
        n0 = we_cnt;
        bus_start();
        send_byte(AW_B, a);
        send_byte(8'h05, a);
        send_byte(8'h77, a);
        bus_stop();
        chk("R3 partial no strobe", 32'(we_cnt - n0), 32'd0);
        read_now(w, a);
        chk("R4 pointer from partial write", 32'(w), 32'hA555);

        // R3/R4: pointer-only write
        bus_start();
        send_byte(AW_B, a);
        send_byte(8'hFE, a);
        bus_stop();
        chk("R3 pointer-only no strobe", 32'(we_cnt - n0), 32'd0);
        read_now(w, a);
        chk("R4 low three bits used", 32'(w), 32'hA666);

        // R3: full write interrupted by repeated START is dropped
        bus_start();
        send_byte(AW_B, a);
        send_byte(8'h03, a);
        send_byte(8'hDE, a);
        send_byte(8'hAD, a);
        bus_rstart();
        send_byte(AR_B, a);
        recv_byte(w[15:8], 1'b1);
        recv_byte(w[7:0], 1'b0);
        bus_stop();
        chk("R3 rstart drops write", 32'(we_cnt - n0), 32'd0);
        chk("R3 reg3 unchanged", 32'(w), 32'hA333);

        // R7: surplus byte not acknowledged, write kept
        bus_start();
        send_byte(AW_B, a);
        send_byte(8'h02, a);
        send_byte(8'hBE, a);
        send_byte(8'hEF, a);
        send_byte(8'h55, a);
        chk("R7 surplus nack", 32'(a), 32'd0);
        bus_stop();
        chk("R7 strobe kept", 32'(we_cnt - n0), 32'd1);
        read_sel(3'd2, w);
        chk("R7 data kept", 32'(w), 32'hBEEF);

        // R10: short pulses on both lines leave the write intact
        glitch = 1'b1;
        write_full(3'd1, 16'h0F0F, acks);
        glitch = 1'b0;
        chk("R10 acks under glitches", 32'(acks), 32'hF);
        read_sel(3'd1, w);
        chk("R10 data under glitches", 32'(w), 32'h0F0F);

        // R9: clock held low during the acknowledge
        bus_start();
        for (int i = 7; i >= 0; i--) put_bit(AW_B[i]);
        chk("R1 ack driven", 32'(sda_oe_o), 32'd1);
        wc(TOUT + 100);
        chk("R9 released after timeout", 32'(sda_oe_o), 32'd0);
        bus_stop();
        read_now(w, a);
        chk("R9 recovered read", 32'(w), 32'h0F0F);

        chk("R8 no drive change with SCL high", 32'(oe_hi_chg), 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule